// File: doc/BRIEF.md
# Shared Inductor Access Arbiter

This block decides which of three power-conversion clients may drive a single shared power inductor. The clients are a bias-flip rectifier, which inverts the harvester capacitance voltage near each current zero crossing; a boost converter that makes the high gate-drive rail; and a buck converter that regulates the rectified voltage. Each client raises a request level and receives an acknowledge. The acknowledge is what starts that client's switching pulse on the inductor, so no more than one acknowledge may ever be high.

When the inductor is free, requests seen on a clock edge are resolved by fixed priority. The rectifier wins first, because its flip must land near the zero crossing. The boost converter comes next and the buck converter last. A grant is never taken away early. It stays high until its owner has dropped both its request and its busy flag. After a release the arbiter keeps all acknowledges low for a programmable number of idle cycles, which gives the switches their dead time. Only then does it arbitrate again. One clock domain is used, with a synchronous active-high reset.

Top module: `ind_share_arb`

## Requirements
- R1: While `rst` is high at a rising clock edge, every acknowledge is low after that edge.
- R2: With the arbiter idle and no request high, no acknowledge rises.
- R3: At most one bit of `ack` is high in any cycle.
- R4: Client index 0 (rectifier) beats index 1 (boost), and index 1 beats index 2 (buck), when several requests are seen together at a free edge.
- R5: With the inductor free and the dead-time window over, a request that is high at a rising edge gives its acknowledge right after that same edge.
- R6: A granted acknowledge stays high for as long as its owner holds `req` or `busy` high.
- R7: A request from a higher-priority client does not take away a grant that is already held.
- R8: The acknowledge falls on the first edge at which its owner has both `req` and `busy` low.
- R9: Between the fall of one grant and the rise of the next there are at least `GAP_CYCLES` (default 2) cycles with every acknowledge low. There are exactly that many when another request is already waiting.
- R10: Every request that is held high is granted within a bounded number of cycles, once the holders ahead of it release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_CLIENTS | Request level per client; bit 0 rectifier, bit 1 boost, bit 2 buck |
| busy | input | NUM_CLIENTS | Client is still switching the inductor; holds its grant |
| ack | output | NUM_CLIENTS | One-hot grant per client |

## Verification
Two events can meet in one cycle: a new request from a higher-priority client, and the end of a grant held by a lower-priority one. The bench provokes this first by raising the rectifier request while the buck client holds the inductor, and checks that the buck grant stays put. It then releases the buck client while the rectifier is waiting, and checks that the rectifier is granted only after exactly the dead-time gap. A scoreboard queue holds the expected order of grants, so any wrong priority or unexpected grant shows up as a mismatch.

// File: rtl/ind_arb_pkg.sv
package ind_arb_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } arb_state_t;

    // client index doubles as priority rank (lower wins)
    localparam int CL_FLIP  = 0;
    localparam int CL_BOOST = 1;
    localparam int CL_BUCK  = 2;

endpackage

// File: rtl/ind_arb_pick.sv
module ind_arb_pick #(
    parameter int NUM_CLIENTS = 3
) (
    input  logic [NUM_CLIENTS-1:0] req_i,
    output logic [NUM_CLIENTS-1:0] sel_o,
    output logic                   any_o
);

    logic [NUM_CLIENTS:0] taken;

    assign taken[0] = 1'b0;

    for (genvar gi = 0; gi < NUM_CLIENTS; gi++) begin : g_rank
        assign sel_o[gi]    = req_i[gi] & ~taken[gi];
        assign taken[gi+1]  = taken[gi] | req_i[gi];
    end

    assign any_o = taken[NUM_CLIENTS];

endmodule

// File: rtl/ind_arb_gap.sv
module ind_arb_gap #(
    parameter int GAP_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic open_o
);

    localparam int CW = $clog2(GAP_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(GAP_CYCLES - 1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign open_o = (cnt_q == '0);

endmodule

// File: rtl/ind_share_arb.sv
module ind_share_arb
    import ind_arb_pkg::*;
#(
    parameter int NUM_CLIENTS = 3,
    parameter int GAP_CYCLES  = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_CLIENTS-1:0] req,
    input  logic [NUM_CLIENTS-1:0] busy,
    output logic [NUM_CLIENTS-1:0] ack
);

    typedef struct packed {
        arb_state_t             st;
        logic [NUM_CLIENTS-1:0] grant;
    } arb_regs_t;

    arb_regs_t r_d, r_q;

    logic [NUM_CLIENTS-1:0] pick_sel;
    logic                   pick_any;
    logic                   gap_open;
    logic                   gap_start;
    logic                   owner_active;

    ind_arb_pick #(.NUM_CLIENTS(NUM_CLIENTS)) u_pick (
        .req_i (req),
        .sel_o (pick_sel),
        .any_o (pick_any)
    );

    ind_arb_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
        .clk     (clk),
        .rst     (rst),
        .start_i (gap_start),
        .open_o  (gap_open)
    );

    assign owner_active = |(r_q.grant & (req | busy));

    always_comb begin
        r_d       = r_q;
        gap_start = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (gap_open && pick_any) begin
                    r_d.grant = pick_sel;
                    r_d.st    = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!owner_active) begin
                    r_d.grant = '0;
                    r_d.st    = ST_IDLE;
                    gap_start = 1'b1;
                end
            end
            default: begin
                r_d.grant = '0;
                r_d.st    = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.st    <= ST_IDLE;
            r_q.grant <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack = r_q.grant;

endmodule

// File: rtl/ind_arb_chk.sv
module ind_arb_chk #(
    parameter int NUM_CLIENTS = 3,
    parameter int GAP_CYCLES  = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic [NUM_CLIENTS-1:0] req,
    input logic [NUM_CLIENTS-1:0] busy,
    input logic [NUM_CLIENTS-1:0] ack
);

    localparam int ZW = $clog2(GAP_CYCLES + 1) + 1;

    logic [ZW-1:0] zrun;

    always_ff @(posedge clk) begin
        if (rst)                         zrun <= ZW'(GAP_CYCLES);
        else if (ack != '0)              zrun <= '0;
        else if (zrun < ZW'(GAP_CYCLES)) zrun <= zrun + 1'b1;
    end

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> (ack == '0));

    // R3
    a_r3_one_grant: assert property (@(posedge clk) disable iff (rst) $onehot0(ack));

    // R2, R5: a grant only rises for a client that was requesting
    a_r5_grant_from_req: assert property (@(posedge clk) disable iff (rst)
        (ack == '0) |=> ((ack == '0) || ((ack & $past(req)) != '0)));

    // R2
    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        ((ack == '0) && (req == '0)) |=> (ack == '0));

    // R6, R7
    a_r6_hold_grant: assert property (@(posedge clk) disable iff (rst)
        ((ack & (req | busy)) != '0) |=> (ack == $past(ack)));

    // R8
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        ((ack != '0) && ((ack & (req | busy)) == '0)) |=> (ack == '0));

    // R9
    a_r9_dead_time: assert property (@(posedge clk) disable iff (rst)
        ((ack != '0) && ($past(ack) == '0)) |-> (zrun >= ZW'(GAP_CYCLES)));

endmodule

bind ind_share_arb ind_arb_chk #(
    .NUM_CLIENTS (NUM_CLIENTS),
    .GAP_CYCLES  (GAP_CYCLES)
) u_chk (
    .clk  (clk),
    .rst  (rst),
    .req  (req),
    .busy (busy),
    .ack  (ack)
);

// File: tb/sim_ind_share_arb.sv
module sim_ind_share_arb;

    localparam int N   = 3;
    localparam int GAP = 2;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] busy = '0;
    logic [N-1:0] ack;

    int n_chk = 0;
    int n_bad = 0;
    int excl_bad = 0;
    int last_gap = 0;
    int zrun = 0;
    int exp_q[$];
    logic [N-1:0] ack_prev = '0;

    always #5 clk = ~clk;

    ind_share_arb #(.NUM_CLIENTS(N), .GAP_CYCLES(GAP)) u0 (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .busy (busy),
        .ack  (ack)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int idx_of(input logic [N-1:0] v);
        for (int i = 0; i < N; i++) if (v[i]) return i;
        return -1;
    endfunction

    // monitor: scoreboard of grant order, exclusion and dead time
    always @(negedge clk) begin
        if (rst) begin
            zrun = GAP;
        end else begin
            if ($countones(ack) > 1) excl_bad++;
            if (ack != '0 && ack_prev == '0) begin
                last_gap = zrun;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected grant", idx_of(ack), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(idx_of(ack) == e, "R4 grant order", idx_of(ack), e);
                end
                check(zrun >= GAP, "R9 dead time", zrun, GAP);
            end
            if (ack == '0) zrun++;
            else           zrun = 0;
        end
        ack_prev = ack;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // wait for grant (R10), hold, then busy tail (R6), release (R8)
    task automatic serve(input int idx, input int hold, input int tail);
        int w;
        w = 0;
        while (!ack[idx] && w < 100) begin
            @(negedge clk);
            w++;
        end
        check(ack[idx] == 1'b1, "R10 eventual grant", int'(ack[idx]), 1);
        cyc(hold);
        req[idx]  = 1'b0;
        busy[idx] = 1'b1;
        cyc(tail);
        check(ack[idx] == 1'b1, "R6 busy holds grant", int'(ack[idx]), 1);
        busy[idx] = 1'b0;
        cyc(1);
        check(ack == '0, "R8 release", int'(ack), 0);
    endtask

    initial begin
        int wd;
        wd = 0;
        while (wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: requests high during reset do not grant
        req = '1;
        cyc(3);
        check(ack == '0, "R1 reset clears", int'(ack), 0);
        req = '0;
        @(negedge clk);
        rst = 1'b0;

        // R2: idle without requests
        cyc(6);
        check(ack == '0, "R2 idle no grant", int'(ack), 0);

        // R5: one-edge latency for buck alone
        exp_q.push_back(2);
        req[2] = 1'b1;
        cyc(1);
        check(ack == 3'b100, "R5 grant latency", int'(ack), 4);
        serve(2, 3, 2);
        cyc(4);

        // R4: all three at once, priority order
        exp_q.push_back(0);
        exp_q.push_back(1);
        exp_q.push_back(2);
        req = 3'b111;
        serve(0, 2, 1);
        serve(1, 1, 3);
        check(last_gap == GAP, "R9 exact gap", last_gap, GAP);
        serve(2, 2, 1);
        cyc(4);

        // R7: rectifier request during a buck grant
        exp_q.push_back(2);
        exp_q.push_back(0);
        req[2] = 1'b1;
        cyc(1);
        req[0] = 1'b1;
        cyc(3);
        check(ack == 3'b100, "R7 no preemption", int'(ack), 4);
        req[2] = 1'b0;
        cyc(1);
        check(ack == '0, "R8 release with waiter", int'(ack), 0);
        serve(0, 1, 1);
        check(last_gap == GAP, "R9 gap before waiter", last_gap, GAP);
        cyc(4);

        // R1: reset in the middle of a grant
        exp_q.push_back(1);
        req[1] = 1'b1;
        cyc(2);
        check(ack == 3'b010, "R5 boost granted", int'(ack), 2);
        rst = 1'b1;
        req[1] = 1'b0;
        cyc(1);
        check(ack == '0, "R1 mid-grant reset", int'(ack), 0);
        rst = 1'b0;
        cyc(4);

        // R2: busy alone without request does not grant
        busy[1] = 1'b1;
        cyc(3);
        check(ack == '0, "R2 busy alone no grant", int'(ack), 0);
        busy[1] = 1'b0;
        cyc(2);

        check(excl_bad == 0, "R3 single grant", excl_bad, 0);
        check(exp_q.size() == 0, "R10 all expected grants seen", exp_q.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule